// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. It holds three banks of 32 pins each and sits behind a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Global pin `n` belongs to bank `n/32` at bit `n%32`. Each bank has its own output latch and direction mask, and software updates the output latch either directly or through set and clear strobes that only touch the bits written as one.

The pin inputs pass through a synchronizer. They can then be inverted per pin, and each pin is watched for rising edges, falling edges, a high level or a low level. Four independent enable masks choose which of these conditions count for each pin. A qualifying event latches a bit in the bank's pending-status register. Edge events also latch a bit in a separate edge-record register. Software clears both registers by writing ones. A single interrupt line is raised while any pending bit in any bank is set.

The register type sits in address bits [7:4] and the bank in bits [3:2]. The three banks of one register type therefore occupy adjacent words.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset, every register in every bank reads 0, `pin_out` and `pin_oe` are all 0, and `irq` is 0.
- R2: An access decodes the register type from `bus_addr[7:4]` and the bank from `bus_addr[3:2]`. `bus_addr[1:0]` must be 0. Type codes are: 0 direction, 1 polarity, 2 data, 3 set, 4 clear, 5 rise-enable, 6 fall-enable, 7 high-enable, 8 low-enable, 9 pending status, 10 edge record. Bank index 3, type codes 11 to 15 and misaligned addresses read 0, and writes to them change no state.
- R3: Bit `i` of a bank's direction register drives `pin_oe[32*bank+i]`. A value of 1 makes the pin an output.
- R4: A write to the data type loads the bank's output latch. A write to set ORs the written ones into the latch, and a write to clear removes them. Zero bits leave the latch unchanged. `pin_out` shows the latch. Reads of the set and clear types return the latch.
- R5: A read of the data type returns the pin input levels, delayed by the two synchronizer flops and not inverted.
- R6: A polarity bit of 1 inverts that pin's input before event detection. Polarity resets to 0, which gives normal sense.
- R7: Suppose a pin changes between clock edges, with the matching rise-enable or fall-enable bit set. The pending bit and `irq` are then set after the third following rising clock edge. A change in the direction whose enable is clear sets nothing.
- R8: While a pin's sensed level is high with its high-enable bit set, or low with its low-enable bit set, its pending bit is set on every clock.
- R9: Writing 1 to a pending bit clears it, and writing 0 has no effect. If a new event and a clearing write hit the same bit on the same clock, the bit stays set.
- R10: The edge-record bit of a pin is set together with its pending bit only for edge events, never for level events. It is cleared by writing 1 to the edge-record type.
- R11: `irq` is high exactly while at least one pending bit in any bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 96 | Pin input levels, asynchronous |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables, 1 = output |
| irq | output | 1 | Shared interrupt, high while any pending bit is set |

## Verification
A wrong internal state shows at the ports in one of three ways.

- A corrupted output latch or direction mask appears on `pin_out` or `pin_oe` on the clock after the write that caused it.
- An error in the synchronizer or the previous-value register shifts `irq` away from the third rising edge after a pin change, or creates an edge where none occurred. A bench that samples `irq` on the second and third cycles catches this.
- A pending bit that is lost, stuck or cleared by mistake shows up on the next status read and on `irq` in the same cycle. Reading the edge-record register exposes confusion between level events and edge events.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   localparam int BUS_W = 32;

   // register type codes, decoded from address bits [7:4]
   typedef enum logic [3:0] {
      RT_DIR  = 4'd0,
      RT_POL  = 4'd1,
      RT_DATA = 4'd2,
      RT_DSET = 4'd3,
      RT_DCLR = 4'd4,
      RT_RISE = 4'd5,
      RT_FALL = 4'd6,
      RT_HIGH = 4'd7,
      RT_LOW  = 4'd8,
      RT_STAT = 4'd9,
      RT_EDGE = 4'd10
   } reg_type_e;

   localparam int LAST_TYPE = 10;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);

   if (STAGES < 0) begin : g_bad_stages
      $error("gpio_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stage_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= '0;
         end else begin
            stage_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end

      assign d_out = stage_q[STAGES-1];
   end

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sense,
   input  logic [W-1:0] en_rise,
   input  logic [W-1:0] en_fall,
   input  logic [W-1:0] en_high,
   input  logic [W-1:0] en_low,
   output logic [W-1:0] any_evt,
   output logic [W-1:0] edge_evt
);

   logic [W-1:0] prev_q;
   logic [W-1:0] rise_hit;
   logic [W-1:0] fall_hit;
   logic [W-1:0] lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sense;
   end

   always_comb begin
      rise_hit = sense & ~prev_q & en_rise;
      fall_hit = ~sense & prev_q & en_fall;
      lvl_hit  = (sense & en_high) | (~sense & en_low);
      edge_evt = rise_hit | fall_hit;
      any_evt  = edge_evt | lvl_hit;
   end

   // a rising hit needs the previous sensed value to have been low
   AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rise_hit & $past(sense)) == '0)); // R7

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  reg_type_e    rtype,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_raw,
   output logic [W-1:0] rdata,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] status_o
);

   logic [W-1:0] dir_q, pol_q, out_q;
   logic [W-1:0] ren_q, fen_q, hen_q, len_q;
   logic [W-1:0] stat_q, edge_q;
   logic [W-1:0] pin_sync, sense;
   logic [W-1:0] any_evt, edge_evt;
   logic [W-1:0] stat_clr, edge_clr;

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_raw),
      .d_out (pin_sync)
   );

   assign sense = pin_sync ^ pol_q;

   gpio_detect #(.W(W)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .sense    (sense),
      .en_rise  (ren_q),
      .en_fall  (fen_q),
      .en_high  (hen_q),
      .en_low   (len_q),
      .any_evt  (any_evt),
      .edge_evt (edge_evt)
   );

   // configuration and output latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         pol_q <= '0;
         out_q <= '0;
         ren_q <= '0;
         fen_q <= '0;
         hen_q <= '0;
         len_q <= '0;
      end else if (wr_en) begin
         case (rtype)
            RT_DIR:  dir_q <= wdata;
            RT_POL:  pol_q <= wdata;
            RT_DATA: out_q <= wdata;
            RT_DSET: out_q <= out_q | wdata;
            RT_DCLR: out_q <= out_q & ~wdata;
            RT_RISE: ren_q <= wdata;
            RT_FALL: fen_q <= wdata;
            RT_HIGH: hen_q <= wdata;
            RT_LOW:  len_q <= wdata;
            default: ;
         endcase
      end
   end

   // write-one-to-clear masks; a fresh event overrides the clear
   assign stat_clr = (wr_en && rtype == RT_STAT) ? wdata : '0;
   assign edge_clr = (wr_en && rtype == RT_EDGE) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         edge_q <= '0;
      end else begin
         stat_q <= (stat_q & ~stat_clr) | any_evt;
         edge_q <= (edge_q & ~edge_clr) | edge_evt;
      end
   end

   always_comb begin
      case (rtype)
         RT_DIR:  rdata = dir_q;
         RT_POL:  rdata = pol_q;
         RT_DATA: rdata = pin_sync;
         RT_DSET: rdata = out_q;
         RT_DCLR: rdata = out_q;
         RT_RISE: rdata = ren_q;
         RT_FALL: rdata = fen_q;
         RT_HIGH: rdata = hen_q;
         RT_LOW:  rdata = len_q;
         RT_STAT: rdata = stat_q;
         RT_EDGE: rdata = edge_q;
         default: rdata = '0;
      endcase
   end

   assign pin_out  = out_q;
   assign pin_oe   = dir_q;
   assign status_o = stat_q;

   AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rtype == RT_DSET) |=> ((pin_out & $past(wdata)) == $past(wdata))); // R4
   AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rtype == RT_DCLR) |=> ((pin_out & $past(wdata)) == '0)); // R4
   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~status_o & $past(any_evt)) == '0)); // R9
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & $past(stat_clr & ~any_evt)) == '0)); // R9
   AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~status_o & $past(status_o & ~stat_clr)) == '0)); // R9
   AST_EDGE_IMPLIES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((edge_q & ~$past(edge_q)) & ~status_o) == '0)); // R10

endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int PIN_W      = NUM_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe,
   output logic              irq
);

   localparam int BSEL_W = 2;

   if (NUM_BANKS < 1 || NUM_BANKS > (1 << BSEL_W)) begin : g_bad_banks
      $error("banked_gpio_ctrl: NUM_BANKS must be 1..4");
   end
   if (BANK_W != BUS_W) begin : g_bad_width
      $error("banked_gpio_ctrl: BANK_W must equal the bus width");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("banked_gpio_ctrl: ADDR_W must be at least 8");
   end

   logic [3:0]        type_code;
   logic [BSEL_W-1:0] bank_idx;
   logic              upper_zero;
   logic              addr_ok;
   reg_type_e         rtype;

   assign type_code = bus_addr[7:4];
   assign bank_idx  = bus_addr[3:2];
   assign rtype     = reg_type_e'(type_code);

   if (ADDR_W > 8) begin : g_upper
      assign upper_zero = (bus_addr[ADDR_W-1:8] == '0);
   end else begin : g_no_upper
      assign upper_zero = 1'b1;
   end

   assign addr_ok = upper_zero && (bus_addr[1:0] == 2'b00)
                  && (int'(type_code) <= LAST_TYPE)
                  && (int'(bank_idx) < NUM_BANKS);

   logic [NUM_BANKS-1:0]             bank_wr;
   logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rdata;
   logic [NUM_BANKS-1:0][BANK_W-1:0] bank_status;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_wr[b] = bus_we && addr_ok && (int'(bank_idx) == b);

      gpio_bank #(.W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bank_wr[b]),
         .rtype    (rtype),
         .wdata    (bus_wdata),
         .pin_raw  (pin_in[b*BANK_W +: BANK_W]),
         .rdata    (bank_rdata[b]),
         .pin_out  (pin_out[b*BANK_W +: BANK_W]),
         .pin_oe   (pin_oe[b*BANK_W +: BANK_W]),
         .status_o (bank_status[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr_ok && int'(bank_idx) == b) bus_rdata = bank_rdata[b];
      end
   end

   always_comb begin
      irq = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) irq = irq | (|bank_status[b]);
   end

   AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_wr)); // R2
   AST_BAD_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_ok) |-> (bank_wr == '0)); // R2
   AST_BAD_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_ok) |-> (bus_rdata == '0)); // R2

endmodule

// File: tb/sim_banked_gpio_ctrl.sv
module sim_banked_gpio_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [95:0] pin_in = '0;
   logic [95:0] pin_out;
   logic [95:0] pin_oe;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   banked_gpio_ctrl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   localparam int T_DIR = 0, T_POL = 1, T_DATA = 2, T_SET = 3, T_CLR = 4;
   localparam int T_RISE = 5, T_FALL = 6, T_HIGH = 7, T_LOW = 8;
   localparam int T_STAT = 9, T_EDGE = 10;

   function automatic logic [7:0] ra(int t, int b);
      return 8'(t * 16 + b * 4);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 v = bus_rdata;
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v, lat;
      int pins[4] = '{0, 7, 16, 31};
      #55 rst_n = 1'b1;
      wait_cyc(2);

      // R1: everything at zero after reset
      for (int t = 0; t <= 10; t++)
         for (int b = 0; b < 3; b++) begin
            rd(ra(t, b), v); check("R1 reset read", v, 32'h0);
         end
      check("R1 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'h0);
      check("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64], 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);

      // R3 / R4: direction and output latch per bank
      for (int b = 0; b < 3; b++) begin
         logic [31:0] dpat, base, smask, cmask;
         dpat  = 32'h1234_5678 ^ (32'h0F0F_0F0F << b);
         base  = 32'hA5A5_A5A5 + 32'(b * 32'h0101_0101);
         smask = 32'h0F00_000F << b;
         cmask = 32'hF000_0301 >> b;
         wr(ra(T_DIR, b), dpat);
         check("R3 pin_oe", pin_oe[b*32 +: 32], dpat);
         wr(ra(T_DATA, b), base);
         check("R4 data write", pin_out[b*32 +: 32], base);
         wr(ra(T_SET, b), smask);
         lat = base | smask;
         check("R4 set", pin_out[b*32 +: 32], lat);
         wr(ra(T_CLR, b), cmask);
         lat = lat & ~cmask;
         check("R4 clear", pin_out[b*32 +: 32], lat);
         rd(ra(T_SET, b), v); check("R4 set readback", v, lat);
         wr(ra(T_SET, b), 32'h0);
         wr(ra(T_CLR, b), 32'h0);
         check("R4 zero no change", pin_out[b*32 +: 32], lat);
      end

      // R2: bank 3, type 11 and misaligned writes are ignored and read 0
      lat = pin_out[31:0];
      wr(ra(T_DATA, 3), 32'hFFFF_FFFF);
      wr(ra(11, 0), 32'hFFFF_FFFF);
      wr(8'h21, 32'hFFFF_FFFF);
      check("R2 ignored writes bank0", pin_out[31:0], lat);
      rd(ra(T_DIR, 3), v); check("R2 bank3 read", v, 32'h0);
      rd(ra(11, 1), v);    check("R2 type11 read", v, 32'h0);
      rd(8'h02, v);        check("R2 misaligned read", v, 32'h0);

      // R5: data read returns synchronized pin levels
      for (int b = 0; b < 3; b++) begin
         logic [31:0] ip;
         ip = 32'hC33C_5AA5 ^ 32'(b * 32'h1111_1111);
         @(negedge clk); pin_in[b*32 +: 32] = ip;
         wait_cyc(2);
         rd(ra(T_DATA, b), v); check("R5 data read", v, ip);
      end
      @(negedge clk); pin_in = '0;
      wait_cyc(4);

      // R7 / R9 / R10 / R11: edge sweep over banks and pins
      for (int b = 0; b < 3; b++)
         for (int k = 0; k < 4; k++) begin
            int p; logic [31:0] m;
            p = pins[k]; m = 32'h1 << p;
            wr(ra(T_RISE, b), m);
            @(negedge clk); pin_in[b*32 + p] = 1'b1;
            @(negedge clk);
            @(negedge clk); check("R7 irq not yet", {31'h0, irq}, 32'h0);
            @(negedge clk); check("R7 irq third edge", {31'h0, irq}, 32'h1);
            rd(ra(T_STAT, b), v); check("R7 rise status", v, m);
            rd(ra(T_EDGE, b), v); check("R10 edge record", v, m);
            wr(ra(T_STAT, b), 32'h0);
            rd(ra(T_STAT, b), v); check("R9 zero write keeps", v, m);
            wr(ra(T_STAT, b), m);
            rd(ra(T_STAT, b), v); check("R9 w1c", v, 32'h0);
            check("R11 irq low", {31'h0, irq}, 32'h0);
            wr(ra(T_EDGE, b), m);
            rd(ra(T_EDGE, b), v); check("R10 edge w1c", v, 32'h0);
            @(negedge clk); pin_in[b*32 + p] = 1'b0;
            wait_cyc(4);
            rd(ra(T_STAT, b), v); check("R7 fall ignored with rise only", v, 32'h0);
            wr(ra(T_FALL, b), m);
            @(negedge clk); pin_in[b*32 + p] = 1'b1;
            wait_cyc(4);
            rd(ra(T_STAT, b), v); check("R7 rise still seen", v, m);
            wr(ra(T_STAT, b), m);
            wr(ra(T_EDGE, b), m);
            @(negedge clk); pin_in[b*32 + p] = 1'b0;
            wait_cyc(4);
            rd(ra(T_STAT, b), v); check("R7 fall status", v, m);
            wr(ra(T_RISE, b), 32'h0);
            wr(ra(T_FALL, b), 32'h0);
            wr(ra(T_STAT, b), m);
            wr(ra(T_EDGE, b), m);
         end

      // R8 / R9 / R10: high level persists through clears
      wr(ra(T_HIGH, 1), 32'h0000_0100);
      @(negedge clk); pin_in[32 + 8] = 1'b1;
      wait_cyc(4);
      rd(ra(T_STAT, 1), v); check("R8 high level", v, 32'h0000_0100);
      wr(ra(T_STAT, 1), 32'h0000_0100);
      rd(ra(T_STAT, 1), v); check("R9 event wins over clear", v, 32'h0000_0100);
      rd(ra(T_EDGE, 1), v); check("R10 level not recorded", v, 32'h0);
      wr(ra(T_HIGH, 1), 32'h0);
      wr(ra(T_STAT, 1), 32'h0000_0100);
      rd(ra(T_STAT, 1), v); check("R8 cleared after disable", v, 32'h0);
      @(negedge clk); pin_in[32 + 8] = 1'b0;
      wait_cyc(4);

      // R6: inverted sense makes a low pin look high
      wr(ra(T_POL, 2), 32'h0000_0020);
      rd(ra(T_POL, 2), v); check("R6 pol readback", v, 32'h0000_0020);
      wr(ra(T_HIGH, 2), 32'h0000_0020);
      wait_cyc(2);
      rd(ra(T_STAT, 2), v); check("R6 inverted high", v, 32'h0000_0020);
      wr(ra(T_HIGH, 2), 32'h0);
      wr(ra(T_POL, 2), 32'h0);
      wr(ra(T_STAT, 2), 32'hFFFF_FFFF);
      rd(ra(T_STAT, 2), v); check("R6 normal sense quiet", v, 32'h0);

      // R8 low level, R11 shared line across banks
      wr(ra(T_LOW, 0), 32'h8000_0000);
      wr(ra(T_LOW, 2), 32'h0000_0001);
      wait_cyc(2);
      check("R11 irq two banks", {31'h0, irq}, 32'h1);
      wr(ra(T_LOW, 0), 32'h0);
      wr(ra(T_STAT, 0), 32'h8000_0000);
      check("R11 irq other bank", {31'h0, irq}, 32'h1);
      rd(ra(T_STAT, 2), v); check("R8 low level", v, 32'h0000_0001);
      wr(ra(T_LOW, 2), 32'h0);
      wr(ra(T_STAT, 2), 32'h0000_0001);
      check("R11 irq all clear", {31'h0, irq}, 32'h0);

      finish_run();
   end

endmodule